// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps the tag, valid and dirty state for every line of a set-associative cache. It also keeps a tree pseudo-LRU replacement state for each set. For each access it takes an address and a read/write flag and reports what happened: a hit, a fill into an empty way, an eviction of a clean line, or an eviction of a dirty line. The cache controller around it uses that code to decide whether a refill and a writeback are needed. Data storage and bus transfers are handled outside the block.

The address is divided into line offset, set index and tag, with every width set by a parameter. Three maintenance commands act on the whole directory in one cycle. The first clears every dirty bit and keeps the lines. The second clears every valid bit. The third returns every replacement tree to zero. The lookup is combinational. The state update and the result register both load on the clock edge that takes the access, so the outcome appears one cycle after the request.

Top module: `cache_tag_dir`

## Requirements
- R1: With OFF_W = log2(LINE_BYTES) and SET_W = log2(SETS), the set index is req_addr[OFF_W +: SET_W] and the tag is req_addr[OFF_W+SET_W +: TAG_W]. The offset bits and any address bits above the tag have no effect on the outcome.
- R2: An access is accepted when req_valid is high and no command is present. rsp_valid is high for exactly the one cycle that follows an accepted access. rsp_outcome then holds 2'b00 for hit, 2'b01 for miss-fill, 2'b10 for clean eviction and 2'b11 for dirty eviction.
- R3: An access whose tag matches a valid line in its set reports hit. That line's dirty bit becomes its old value OR the write flag.
- R4: On a miss with at least one invalid way, the lowest-numbered invalid way takes the new tag. Its valid bit is set, its dirty bit is set to the write flag, and the outcome is miss.
- R5: On a miss in a full set, the victim comes from a tree of WAYS-1 bits. Starting at node 0, a bit of 0 leads to child 2n+1 and a bit of 1 leads to child 2n+2. At bottom node b, the victim is way 2(b-(WAYS/2-1)) plus the bit. The victim takes the new tag and its dirty bit is set to the write flag.
- R6: An eviction reports 2'b11 when the victim's previous dirty bit was set, and 2'b10 when it was clear.
- R7: Every hit, fill or eviction updates the set's tree so that it points away from the accessed way. The bottom node over the way is set to the inverse of the way's lowest bit. Each ancestor is set to 1 when it is reached from its left child and to 0 when reached from its right child.
- R8: flush clears every dirty bit and leaves tags and valid bits as they were.
- R9: inval clears every valid bit, so the next access to any line reports miss.
- R10: clr_repl sets every replacement bit of every set to zero.
- R11: After reset, no line is valid, every tree is zero, rsp_valid is low and rsp_outcome is 2'b00.
- R12: In a cycle where flush, inval or clr_repl is high, the access is dropped. It changes no state and produces no rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | Access is a write |
| req_addr | input | ADDR_W | Access address |
| flush | input | 1 | Clear all dirty bits |
| inval | input | 1 | Clear all valid bits |
| clr_repl | input | 1 | Zero all replacement trees |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_outcome | output | 2 | Outcome code of the previous access |

## Verification
The properties assume that WAYS is a power of two and at least 2. They also assume that the inputs are driven to zero while reset is held, so that the first sampled history after reset is quiet. The stimulus only changes inputs on the falling clock edge. It draws tags from a small pool so that hits, full sets and evictions all occur often. Commands are rare, and some of them coincide with access requests so that the dropped-access rule is exercised.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;

    // Outcome code reported one cycle after an accepted access
    typedef enum logic [1:0] {
        OUT_HIT         = 2'b00,
        OUT_MISS        = 2'b01,
        OUT_CLEAN_EVICT = 2'b10,
        OUT_DIRTY_EVICT = 2'b11
    } outcome_e;

endpackage

// File: rtl/cd_way_match.sv
// Compares one set's tags against the request tag and finds the first free way.
module cd_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [WAYS-1:0]            row_valid,
    input  logic [TAG_W-1:0]           tag_i,
    output logic [WAYS-1:0]            hit_vec,
    output logic                       hit_any,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       free_any,
    output logic [WAY_W-1:0]           free_way
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = row_valid[w] && (row_tag[w] == tag_i);
    end

    assign hit_any  = |hit_vec;
    assign free_any = ~&row_valid;

    always_comb begin
        hit_way  = '0;
        free_way = '0;
        // walk downward so the lowest index is assigned last and wins
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
            if (!row_valid[w]) free_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/cd_plru.sv
// Tree pseudo-LRU: victim choice and the tree update for an accessed way.
module cd_plru #(
    parameter int WAYS = 4,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int NODES  = WAYS - 1,
    localparam int LEVELS = $clog2(WAYS),
    localparam int BOTTOM = WAYS / 2 - 1
) (
    input  logic [NODES-1:0] tree_i,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim_o,
    output logic [NODES-1:0] tree_o
);

    // follow the bits from the root down to a leaf pair
    always_comb begin
        int node;
        node = 0;
        for (int l = 0; l < LEVELS - 1; l++) begin
            node = tree_i[node] ? 2 * node + 2 : 2 * node + 1;
        end
        victim_o = WAY_W'(2 * (node - BOTTOM) + (tree_i[node] ? 1 : 0));
    end

    // climb from the accessed leaf pair to the root, pointing away from it
    always_comb begin
        int node;
        tree_o = tree_i;
        node   = int'(touch_way >> 1) + BOTTOM;
        tree_o[node] = ~touch_way[0];
        for (int l = 0; l < LEVELS - 1; l++) begin
            tree_o[(node - 1) / 2] = ((node % 2) == 1);
            node = (node - 1) / 2;
        end
    end

endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
    import cache_dir_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int TAG_W      = 8,
    parameter int SETS       = 4,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              flush,
    input  logic              inval,
    input  logic              clr_repl,
    output logic              rsp_valid,
    output logic [1:0]        rsp_outcome
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int NODES = WAYS - 1;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tags;
        logic [SETS-1:0][WAYS-1:0]            valid;
        logic [SETS-1:0][WAYS-1:0]            dirty;
        logic [SETS-1:0][NODES-1:0]           plru;
        logic                                 rsp_valid;
        outcome_e                             rsp_out;
    } dir_state_t;

    dir_state_t state_d, state_q;

    logic [SET_W-1:0] set_idx;
    logic [TAG_W-1:0] req_tag;
    logic             cmd_any;
    logic [WAYS-1:0]  hit_vec;
    logic             hit_any, free_any;
    logic [WAY_W-1:0] hit_way, free_way, victim_way, way_sel;
    logic [NODES-1:0] plru_next;

    assign set_idx = req_addr[OFF_W +: SET_W];
    assign req_tag = req_addr[OFF_W + SET_W +: TAG_W];
    assign cmd_any = flush || inval || clr_repl;

    cd_way_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_match (
        .row_tag   (state_q.tags[set_idx]),
        .row_valid (state_q.valid[set_idx]),
        .tag_i     (req_tag),
        .hit_vec   (hit_vec),
        .hit_any   (hit_any),
        .hit_way   (hit_way),
        .free_any  (free_any),
        .free_way  (free_way)
    );

    cd_plru #(
        .WAYS (WAYS)
    ) u_plru (
        .tree_i    (state_q.plru[set_idx]),
        .touch_way (way_sel),
        .victim_o  (victim_way),
        .tree_o    (plru_next)
    );

    // hit way first, then the first empty way, then the tree's victim
    always_comb begin
        if (hit_any)       way_sel = hit_way;
        else if (free_any) way_sel = free_way;
        else               way_sel = victim_way;
    end

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = 1'b0;
        if (cmd_any) begin
            if (flush)    state_d.dirty = '0;
            if (inval)    state_d.valid = '0;
            if (clr_repl) state_d.plru  = '0;
        end else if (req_valid) begin
            state_d.rsp_valid     = 1'b1;
            state_d.plru[set_idx] = plru_next;
            if (hit_any) begin
                state_d.rsp_out = OUT_HIT;
                state_d.dirty[set_idx][way_sel] =
                    state_q.dirty[set_idx][way_sel] | req_write;
            end else begin
                if (free_any)
                    state_d.rsp_out = OUT_MISS;
                else if (state_q.dirty[set_idx][way_sel])
                    state_d.rsp_out = OUT_DIRTY_EVICT;
                else
                    state_d.rsp_out = OUT_CLEAN_EVICT;
                state_d.tags[set_idx][way_sel]  = req_tag;
                state_d.valid[set_idx][way_sel] = 1'b1;
                state_d.dirty[set_idx][way_sel] = req_write;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid   = state_q.rsp_valid;
    assign rsp_outcome = state_q.rsp_out;

endmodule

// File: rtl/cache_tag_dir_chk.sv
module cache_tag_dir_chk #(
    parameter int ADDR_W     = 16,
    parameter int TAG_W      = 8,
    parameter int SETS       = 4,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 16,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int KEY_W = $clog2(SETS) + TAG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              flush,
    input logic              inval,
    input logic              clr_repl,
    input logic              rsp_valid,
    input logic [1:0]        rsp_outcome,
    input logic [WAYS-1:0]   hit_vec
);

    logic             acc;
    logic [KEY_W-1:0] key;
    assign acc = req_valid && !flush && !inval && !clr_repl;
    assign key = req_addr[OFF_W +: KEY_W];

    p_strobe_follows_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    p_no_strobe_when_dropped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    p_repeat_line_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && $past(acc) && key == $past(key)) |=> rsp_outcome == 2'b00);

    p_single_matching_way_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_miss_after_inval_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && $past(inval)) |=> rsp_outcome == 2'b01);

    p_no_dirty_evict_after_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && $past(flush)) |=> rsp_outcome != 2'b11);

    // req_write is part of the checked interface but has no standalone property
    logic unused_ok;
    assign unused_ok = req_write;

endmodule

bind cache_tag_dir cache_tag_dir_chk #(
    .ADDR_W     (ADDR_W),
    .TAG_W      (TAG_W),
    .SETS       (SETS),
    .WAYS       (WAYS),
    .LINE_BYTES (LINE_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .flush       (flush),
    .inval       (inval),
    .clr_repl    (clr_repl),
    .rsp_valid   (rsp_valid),
    .rsp_outcome (rsp_outcome),
    .hit_vec     (hit_vec)
);

// File: tb/cache_tag_dir_test.sv
module cache_tag_dir_test;

    localparam int S = 4;
    localparam int W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic        flush = 1'b0;
    logic        inval = 1'b0;
    logic        clr_repl = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_outcome;

    int n_chk = 0;
    int n_bad = 0;

    cache_tag_dir uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .flush(flush), .inval(inval), .clr_repl(clr_repl),
        .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome)
    );

    always #5 clk = ~clk;

    // reference state
    int m_tag [S][W];
    bit m_val [S][W];
    bit m_dty [S][W];
    bit m_tr  [S][W];

    function automatic logic [15:0] mk(int tag, int set, int off, int hi);
        return {2'(hi), 8'(tag), 2'(set), 4'(off)};
    endfunction

    function automatic int ref_victim(int s);
        int node = 0, lo = 0, size = W;
        forever begin
            if (size == 2) return lo + int'(m_tr[s][node]);
            if (m_tr[s][node]) begin lo += size / 2; node = 2 * node + 2; end
            else node = 2 * node + 1;
            size /= 2;
        end
    endfunction

    function automatic void ref_touch(int s, int way);
        int node = 0, lo = 0, size = W;
        while (size > 1) begin
            int half = size / 2;
            if (way >= lo + half) begin m_tr[s][node] = 0; lo += half; node = 2 * node + 2; end
            else begin m_tr[s][node] = 1; node = 2 * node + 1; end
            size = half;
        end
    endfunction

    function automatic int ref_access(logic [15:0] a, bit wr);
        int s = int'(a[5:4]);
        int t = int'(a[13:6]);
        int way = -1;
        int code;
        for (int w = 0; w < W; w++) if (m_val[s][w] && m_tag[s][w] == t) way = w;
        if (way >= 0) begin
            m_dty[s][way] = m_dty[s][way] | wr;
            ref_touch(s, way);
            return 0;
        end
        for (int w = W - 1; w >= 0; w--) if (!m_val[s][w]) way = w;
        if (way >= 0) code = 1;
        else begin
            way = ref_victim(s);
            code = m_dty[s][way] ? 3 : 2;
        end
        m_tag[s][way] = t; m_val[s][way] = 1; m_dty[s][way] = wr;
        ref_touch(s, way);
        return code;
    endfunction

    task automatic check(bit ok, string rq, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
        end
    endtask

    // one cycle: drive at the falling edge, compare at the next falling edge
    task automatic cyc(bit rv, bit wr, logic [15:0] a, bit fl, bit iv, bit cr,
                       int exp_code, string rq);
        bit ev;
        int ec = 0;
        req_valid = rv; req_write = wr; req_addr = a;
        flush = fl; inval = iv; clr_repl = cr;
        ev = 0;
        if (fl || iv || cr) begin
            for (int s = 0; s < S; s++)
                for (int w = 0; w < W; w++) begin
                    if (fl) m_dty[s][w] = 0;
                    if (iv) m_val[s][w] = 0;
                    if (cr) m_tr[s][w] = 0;
                end
        end else if (rv) begin
            ev = 1;
            ec = ref_access(a, wr);
        end
        @(negedge clk);
        check(rsp_valid == ev, {rq, " R2 strobe"}, int'(rsp_valid), int'(ev));
        if (ev) check(int'(rsp_outcome) == ec, {rq, " R2 model"}, int'(rsp_outcome), ec);
        if (exp_code >= 0)
            check(int'(rsp_outcome) == exp_code, rq, int'(rsp_outcome), exp_code);
    endtask

    task automatic rd(int tag, int set, int exp_code, string rq);
        cyc(1, 0, mk(tag, set, 0, 0), 0, 0, 0, exp_code, rq);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < S; s++)
            for (int w = 0; w < W; w++) begin
                m_tag[s][w] = 0; m_val[s][w] = 0; m_dty[s][w] = 0; m_tr[s][w] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R11 strobe after reset", int'(rsp_valid), 0);
        check(rsp_outcome == 2'b00, "R11 outcome after reset", int'(rsp_outcome), 0);

        // R11, R4: empty directory misses; R1: offset and high bits ignored
        cyc(1, 0, mk(1, 0, 3, 0), 0, 0, 0, 1, "R11 first access misses");
        cyc(1, 0, mk(1, 0, 9, 2), 0, 0, 0, 0, "R1 offset/high bits ignored");
        cyc(1, 1, mk(1, 0, 0, 0), 0, 0, 0, 0, "R3 write hit");
        rd(2, 0, 1, "R4 fill way1");
        rd(3, 0, 1, "R4 fill way2");
        rd(4, 0, 1, "R4 fill way3");
        // tree now points at way0, which holds dirty tag 1
        cyc(1, 1, mk(5, 0, 0, 0), 0, 0, 0, 3, "R6 dirty eviction");
        rd(6, 0, 2, "R5 clean eviction of way2");
        rd(2, 0, 0, "R7 hit on way1");
        rd(7, 0, 2, "R7 victim avoids touched way");
        rd(2, 0, 0, "R7 touched line survives");

        // R8: flush keeps lines, later evictions are clean
        cyc(1, 1, mk(5, 0, 0, 0), 0, 0, 0, 0, "R3 make dirty");
        cyc(1, 1, mk(9, 0, 0, 0), 1, 0, 0, -1, "R12 access with flush dropped");
        rd(5, 0, 0, "R8 line still valid after flush");
        rd(9, 0, 2, "R12 dropped access left no line");
        for (int t = 10; t < 14; t++) rd(t, 0, 2, "R8 eviction clean after flush");

        // R9: invalidate
        cyc(0, 0, '0, 0, 1, 0, -1, "R9 invalidate");
        rd(10, 0, 1, "R9 miss after invalidate");
        rd(12, 0, 1, "R9 second fill after invalidate");

        // R10: clear replacement state
        for (int t = 1; t < 5; t++) rd(t, 1, 1, "R4 fill set1");
        rd(1, 1, 0, "R7 hit way0 set1");
        cyc(1, 0, mk(3, 1, 0, 0), 0, 0, 1, -1, "R12 access with clear dropped");
        rd(5, 1, 2, "R10 victim is way0 after clear");
        rd(1, 1, 2, "R10 evicted line misses");

        // random phase, compared against the reference model
        begin
            int unsigned seed;
            seed = 32'h1bad_c0de;
            void'($urandom(seed));
            for (int i = 0; i < 4000; i++) begin
                int r = int'($urandom_range(99));
                bit fl = (r == 0);
                bit iv = (r == 1);
                bit cr = (r == 2);
                bit rv = ($urandom_range(9) != 0);
                bit wr = $urandom_range(1) == 1;
                logic [15:0] a = mk(int'($urandom_range(7)), int'($urandom_range(3)),
                                    int'($urandom_range(15)), int'($urandom_range(3)));
                cyc(rv, wr, a, fl, iv, cr, -1, "R5 R6 random");
            end
        end

        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2 idle after last access", int'(rsp_valid), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule